// File: doc/BRIEF.md
# Strided Input Sample Formatter

This block feeds a transform engine from a local sample memory. A start pulse loads a configuration. The block then walks memory in a two-level strided pattern. Inside one iteration, consecutive samples are a fixed byte step apart. Consecutive iterations begin a second, independent byte step apart. All iterations run back to back without a new start.

Each fetched word is turned into a complex value with 24-bit real and imaginary parts. The source may be 16-bit or 32-bit, real or complex, signed or unsigned. Narrow data is widened. Wide data loses a programmed number of its most significant bits, with saturation. When the programmed transform length exceeds the number of samples in an iteration, zero samples are appended so that each iteration fills the whole transform.

Samples leave on a valid/ready stream, one per cycle while the consumer is ready. First and last markers frame each iteration, and a one-cycle done pulse closes the job. The memory read port is combinational: the data word for the address on `mem_addr` is expected on `mem_rdata` in the same cycle.

Top module: `sfmt_top`

## Requirements
- R1: During reset and after it, `out_valid` and `done` are 0, and no sample appears until `start` is seen while the block is idle. A reset in the middle of a job stops output on the next cycle.
- R2: Sample s of iteration i is read from the 16-bit byte address `cfg_base + i*cfg_iter_step + s*cfg_step`, which wraps modulo 65536. `cfg_step` may be any value from 0 to 32767.
- R3: The count fields hold count minus one. Each job runs `cfg_iter_m1+1` iterations, and each iteration reads `cfg_cnt_m1+1` samples. The iterations follow each other with no further `start`.
- R4: Let N = 2^`cfg_fft_log2` (exponent capped at 12) and C = `cfg_cnt_m1+1`. When N > C, positions C to N-1 of each iteration output 0 in both parts. Otherwise each iteration outputs exactly C samples.
- R5: In 16-bit mode (`cfg_wide`=0), the real part comes from word bits 15:0 and, for complex data, the imaginary part from bits 31:16. Each part is sign-extended to 24 bits when `cfg_signed`=1 and zero-extended otherwise. Real data (`cfg_cplx`=0) gives an imaginary part of 0.
- R6: In 32-bit mode (`cfg_wide`=1), the real part comes from bits 31:0 and the imaginary part from bits 63:32. Each part is shifted right by 8-`cfg_clip` places (`cfg_clip` from 0 to 8, arithmetic shift when signed). The result is then saturated to [-2^23, 2^23-1] when signed, or to [0, 2^24-1] when unsigned.
- R7: `out_first` is 1 on the first output of every iteration. `out_last` is 1 on the final output of every iteration, padding included.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` and all output fields hold their values. With `out_ready` held at 1, one sample is accepted every cycle until the job ends.
- R9: `done` is 1 for exactly one cycle: the cycle after the final sample of the final iteration is accepted. `out_valid` is 0 in that cycle.
- R10: A `start` pulse during a running job is ignored, and so are changes on the configuration inputs during the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job with the present configuration (idle only) |
| cfg_base | input | 16 | Byte address of the first sample |
| cfg_cnt_m1 | input | 12 | Samples per iteration minus one |
| cfg_step | input | 15 | Byte step between samples |
| cfg_iter_m1 | input | 12 | Iterations minus one |
| cfg_iter_step | input | 16 | Byte step between iteration start addresses |
| cfg_fft_log2 | input | 4 | Base-2 exponent of the transform length |
| cfg_wide | input | 1 | 1: 32-bit parts, 0: 16-bit parts |
| cfg_cplx | input | 1 | 1: complex source, 0: real source |
| cfg_signed | input | 1 | 1: signed source data |
| cfg_clip | input | 4 | MSBs removed from 32-bit parts (0 to 8) |
| mem_addr | output | 16 | Memory byte address being read |
| mem_rdata | input | 64 | Word at `mem_addr`, little-endian bytes, same cycle |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_re | output | 24 | Real part |
| out_im | output | 24 | Imaginary part |
| out_first | output | 1 | First output of an iteration |
| out_last | output | 1 | Last output of an iteration |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The bench targets address wrap past 0xFFFF, the largest step of 32767, and the seam between iterations. A design with a wrong iteration base would repeat or skip rows there, and one with a miscounted minus-one field would emit one sample too many or too few, with the markers and `done` out of place. Padded and unpadded lengths, single-sample iterations, and every data format are covered, including 32-bit words that saturate at both signed limits and at the unsigned limit. A wrapping clip would show up as small garbage values at those points. Back-pressure, a restart attempt in the middle of a job, and a reset in the middle of a job catch designs that drop or alter a held sample, reload their configuration while busy, or keep streaming after reset.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    localparam int ADDR_W  = 16;
    localparam int CNT_W   = 12;
    localparam int STEP_W  = 15;
    localparam int ISTEP_W = 16;
    localparam int LOG_W   = 4;
    localparam int CLIP_W  = 4;
    localparam int COMP_W  = 24;
    localparam int NARROW_W = 16;
    localparam int WIDE_W  = 32;
    localparam int WORD_W  = 2 * WIDE_W;
    localparam int MAX_CLIP = WIDE_W - COMP_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [CNT_W-1:0]   cnt_m1;
        logic [STEP_W-1:0]  step;
        logic [CNT_W-1:0]   iter_m1;
        logic [ISTEP_W-1:0] iter_step;
        logic [LOG_W-1:0]   fft_log2;
        logic               wide;
        logic               cplx;
        logic               sgn;
        logic [CLIP_W-1:0]  clip;
    } sfmt_cfg_t;

    typedef struct packed {
        logic [COMP_W-1:0] re;
        logic [COMP_W-1:0] im;
        logic              first;
        logic              last;
    } sfmt_sample_t;

    // Transform length minus one; exponents past the counter width saturate.
    function automatic logic [CNT_W-1:0] fft_len_m1(input logic [LOG_W-1:0] lg);
        if (int'(lg) >= CNT_W)
            return '1;
        return CNT_W'((1 << lg) - 1);
    endfunction

    function automatic logic [COMP_W-1:0] widen16(input logic [NARROW_W-1:0] x,
                                                 input logic sgn);
        return sgn ? {{(COMP_W-NARROW_W){x[NARROW_W-1]}}, x}
                   : {{(COMP_W-NARROW_W){1'b0}}, x};
    endfunction

    function automatic logic [COMP_W-1:0] narrow32(input logic [WIDE_W-1:0] x,
                                                  input logic sgn,
                                                  input logic [CLIP_W-1:0] clip);
        logic [CLIP_W-1:0]       k;
        logic signed [WIDE_W:0]  ext;
        logic signed [WIDE_W:0]  v;
        logic signed [WIDE_W:0]  smax;
        logic signed [WIDE_W:0]  smin;
        logic signed [WIDE_W:0]  umax;
        k    = (int'(clip) > MAX_CLIP) ? CLIP_W'(MAX_CLIP) : clip;
        ext  = sgn ? {x[WIDE_W-1], x} : {1'b0, x};
        v    = ext >>> (CLIP_W'(MAX_CLIP) - k);
        smax = (WIDE_W+1)'((1 << (COMP_W-1)) - 1);
        smin = -((WIDE_W+1)'(1 << (COMP_W-1)));
        umax = (WIDE_W+1)'((1 << COMP_W) - 1);
        if (sgn) begin
            if (v > smax) return {1'b0, {(COMP_W-1){1'b1}}};
            if (v < smin) return {1'b1, {(COMP_W-1){1'b0}}};
        end else begin
            if (v > umax) return '1;
        end
        return v[COMP_W-1:0];
    endfunction

endpackage

// File: rtl/sfmt_seq.sv
module sfmt_seq
    import sfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  sfmt_cfg_t         cfg_in,
    input  logic              adv,
    output logic              running,
    output sfmt_cfg_t         cfg_q,
    output logic [ADDR_W-1:0] addr,
    output logic              pad,
    output logic              first,
    output logic              last,
    output logic              done
);

    logic [CNT_W-1:0]  samp_idx;
    logic [CNT_W-1:0]  iter_idx;
    logic [CNT_W-1:0]  len_m1;
    logic [CNT_W-1:0]  next_len_m1;
    logic [ADDR_W-1:0] iter_base;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        next_len_m1 = fft_len_m1(cfg_in.fft_log2);
        if (cfg_in.cnt_m1 > next_len_m1)
            next_len_m1 = cfg_in.cnt_m1;
        next_base = iter_base + ADDR_W'(cfg_q.iter_step);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            done      <= 1'b0;
            cfg_q     <= '0;
            addr      <= '0;
            iter_base <= '0;
            samp_idx  <= '0;
            iter_idx  <= '0;
            len_m1    <= '0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    running   <= 1'b1;
                    cfg_q     <= cfg_in;
                    addr      <= cfg_in.base;
                    iter_base <= cfg_in.base;
                    samp_idx  <= '0;
                    iter_idx  <= '0;
                    len_m1    <= next_len_m1;
                end
            end else if (adv) begin
                if (samp_idx == len_m1) begin
                    if (iter_idx == cfg_q.iter_m1) begin
                        running <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        iter_idx  <= iter_idx + 1'b1;
                        iter_base <= next_base;
                        addr      <= next_base;
                        samp_idx  <= '0;
                    end
                end else begin
                    samp_idx <= samp_idx + 1'b1;
                    addr     <= addr + ADDR_W'(cfg_q.step);
                end
            end
        end
    end

    assign pad   = samp_idx > cfg_q.cnt_m1;
    assign first = samp_idx == '0;
    assign last  = samp_idx == len_m1;

endmodule

// File: rtl/sfmt_conv.sv
module sfmt_conv
    import sfmt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              wide,
    input  logic              cplx,
    input  logic              sgn,
    input  logic [CLIP_W-1:0] clip,
    input  logic              pad,
    output logic [COMP_W-1:0] re,
    output logic [COMP_W-1:0] im
);

    localparam int LANES = 2;

    logic [COMP_W-1:0] lane_val [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [NARROW_W-1:0] raw_n;
        logic [WIDE_W-1:0]   raw_w;
        logic                blank;
        assign raw_n = word[NARROW_W*l +: NARROW_W];
        assign raw_w = word[WIDE_W*l +: WIDE_W];
        assign blank = pad || ((l != 0) && !cplx);
        always_comb begin
            if (blank)
                lane_val[l] = '0;
            else if (wide)
                lane_val[l] = narrow32(raw_w, sgn, clip);
            else
                lane_val[l] = widen16(raw_n, sgn);
        end
    end

    assign re = lane_val[0];
    assign im = lane_val[1];

endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
    import sfmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [CNT_W-1:0]   cfg_cnt_m1,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [CNT_W-1:0]   cfg_iter_m1,
    input  logic [ISTEP_W-1:0] cfg_iter_step,
    input  logic [LOG_W-1:0]   cfg_fft_log2,
    input  logic               cfg_wide,
    input  logic               cfg_cplx,
    input  logic               cfg_signed,
    input  logic [CLIP_W-1:0]  cfg_clip,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [COMP_W-1:0]  out_re,
    output logic [COMP_W-1:0]  out_im,
    output logic               out_first,
    output logic               out_last,
    output logic               done
);

    sfmt_cfg_t    cfg_in;
    sfmt_cfg_t    cfg_q;
    sfmt_sample_t smp;
    logic         running;
    logic         pad;
    logic         first;
    logic         last;

    assign cfg_in = '{base: cfg_base, cnt_m1: cfg_cnt_m1, step: cfg_step,
                      iter_m1: cfg_iter_m1, iter_step: cfg_iter_step,
                      fft_log2: cfg_fft_log2, wide: cfg_wide, cplx: cfg_cplx,
                      sgn: cfg_signed, clip: cfg_clip};

    sfmt_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .adv     (out_valid && out_ready),
        .running (running),
        .cfg_q   (cfg_q),
        .addr    (mem_addr),
        .pad     (pad),
        .first   (first),
        .last    (last),
        .done    (done)
    );

    sfmt_conv conv_i (
        .word (mem_rdata),
        .wide (cfg_q.wide),
        .cplx (cfg_q.cplx),
        .sgn  (cfg_q.sgn),
        .clip (cfg_q.clip),
        .pad  (pad),
        .re   (smp.re),
        .im   (smp.im)
    );

    assign smp.first = first;
    assign smp.last  = last;

    assign out_valid = running;
    assign out_re    = smp.re;
    assign out_im    = smp.im;
    assign out_first = smp.first && running;
    assign out_last  = smp.last && running;

endmodule

// File: rtl/sfmt_chk.sv
module sfmt_chk
    import sfmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [COMP_W-1:0] out_re,
    input logic [COMP_W-1:0] out_im,
    input logic              out_first,
    input logic              out_last,
    input logic              done
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !done));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) &&
            $stable(out_im) && $stable(out_first) && $stable(out_last)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_first || out_last) |-> out_valid);

endmodule

bind sfmt_top sfmt_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_first (out_first),
    .out_last  (out_last),
    .done      (done)
);

// File: tb/sfmt_top_tb.sv
module sfmt_top_tb_top;

    typedef struct packed {
        logic [15:0] base;
        logic [11:0] cnt_m1;
        logic [14:0] step;
        logic [11:0] iter_m1;
        logic [15:0] istep;
        logic [3:0]  lg;
        logic        wide;
        logic        cplx;
        logic        sgn;
        logic [3:0]  clip;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0010, 12'd7, 15'd2,     12'd0, 16'h0000, 4'd3, 1'b0, 1'b0, 1'b1, 4'd0},
        '{16'h0100, 12'd4, 15'd4,     12'd2, 16'h0040, 4'd3, 1'b0, 1'b1, 1'b0, 4'd0},
        '{16'h0200, 12'd5, 15'd8,     12'd1, 16'h0030, 4'd2, 1'b1, 1'b1, 1'b1, 4'd0},
        '{16'hFFF0, 12'd3, 15'd8,     12'd1, 16'h0010, 4'd0, 1'b1, 1'b0, 1'b1, 4'd8},
        '{16'h0020, 12'd9, 15'h7FFF,  12'd0, 16'h0000, 4'd4, 1'b1, 1'b1, 1'b0, 4'd4},
        '{16'h0300, 12'd0, 15'd1,     12'd3, 16'h0003, 4'd1, 1'b0, 1'b0, 1'b0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [11:0] cfg_cnt_m1 = '0;
    logic [14:0] cfg_step = '0;
    logic [11:0] cfg_iter_m1 = '0;
    logic [15:0] cfg_iter_step = '0;
    logic [3:0]  cfg_fft_log2 = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_cplx = 1'b0;
    logic        cfg_signed = 1'b0;
    logic [3:0]  cfg_clip = '0;
    logic [15:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_re;
    logic [23:0] out_im;
    logic        out_first;
    logic        out_last;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sfmt_top dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base),
        .cfg_cnt_m1(cfg_cnt_m1), .cfg_step(cfg_step), .cfg_iter_m1(cfg_iter_m1),
        .cfg_iter_step(cfg_iter_step), .cfg_fft_log2(cfg_fft_log2),
        .cfg_wide(cfg_wide), .cfg_cplx(cfg_cplx), .cfg_signed(cfg_signed),
        .cfg_clip(cfg_clip), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re),
        .out_im(out_im), .out_first(out_first), .out_last(out_last), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [63:0] mem_word(input logic [15:0] a);
        logic [63:0] w;
        for (int j = 0; j < 8; j++) w[8*j +: 8] = mem_byte(a + 16'(j));
        return w;
    endfunction

    always_comb mem_rdata = mem_word(mem_addr);

    function automatic logic [23:0] model(input logic [31:0] raw, input bit wide,
                                          input bit sgn, input int clip);
        longint v;
        if (!wide) begin
            v = longint'(raw[15:0]);
            if (sgn && raw[15]) v -= 65536;
            return v[23:0];
        end
        v = longint'(raw);
        if (sgn && raw[31]) v -= 64'sh1_0000_0000;
        v = v >>> (8 - clip);
        if (sgn) begin
            if (v > 8388607) v = 8388607;
            if (v < -8388608) v = -8388608;
        end else if (v > 16777215) begin
            v = 16777215;
        end
        return v[23:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        cfg_base = v.base; cfg_cnt_m1 = v.cnt_m1; cfg_step = v.step;
        cfg_iter_m1 = v.iter_m1; cfg_iter_step = v.istep; cfg_fft_log2 = v.lg;
        cfg_wide = v.wide; cfg_cplx = v.cplx; cfg_signed = v.sgn; cfg_clip = v.clip;
    endtask

    // bp: back-pressure pattern; poke: restart attempt in mid-job
    task automatic run_vec(input vec_t v, input bit bp, input bit poke, input string tag);
        int len;
        int total;
        int k;
        logic [49:0] held;
        bit   have_held;
        len = (1 << v.lg);
        if (int'(v.cnt_m1) + 1 > len) len = int'(v.cnt_m1) + 1;
        total = (int'(v.iter_m1) + 1) * len;
        k = 0;
        have_held = 1'b0;
        held = '0;
        load(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (k == total) begin
                check({tag, " R3 R9 done after last"}, {62'd0, done, out_valid}, 64'd2);
                @(negedge clk);
                check({tag, " R9 done single"}, {63'd0, done}, 64'd0);
                return;
            end
            if (poke && cyc == 2) begin
                start = 1'b1;
                cfg_base = ~v.base;
                cfg_cnt_m1 = 12'd1;
            end else if (poke && cyc == 3) begin
                start = 1'b0;
            end
            out_ready = bp ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (!out_valid) begin
                check({tag, " R8 valid while pending"}, {63'd0, out_valid}, 64'd1);
            end
            if (have_held) begin
                check({tag, " R8 held sample stable"},
                      {14'd0, out_re, out_im, out_first, out_last}, {14'd0, held});
                have_held = 1'b0;
            end
            if (out_valid && out_ready) begin
                int i;
                int s;
                logic [15:0] a;
                logic [63:0] w;
                logic [23:0] er;
                logic [23:0] ei;
                i = k / len;
                s = k % len;
                a = v.base + 16'(i) * v.istep + 16'(s) * 16'(v.step);
                w = mem_word(a);
                er = model(v.wide ? w[31:0] : {16'd0, w[15:0]}, v.wide, v.sgn, int'(v.clip));
                ei = model(v.wide ? w[63:32] : {16'd0, w[31:16]}, v.wide, v.sgn, int'(v.clip));
                if (!v.cplx) ei = '0;
                if (s > int'(v.cnt_m1)) begin
                    er = '0;
                    ei = '0;
                end
                check({tag, " R2 R4 R5 R6 R7 sample"},
                      {14'd0, out_re, out_im, out_first, out_last},
                      {14'd0, er, ei, (s == 0), (s == len - 1)});
                k++;
            end else if (out_valid) begin
                held = {out_re, out_im, out_first, out_last};
                have_held = 1'b1;
            end
            @(negedge clk);
        end
        check({tag, " R3 job never ended"}, 64'd0, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset quiet", {62'd0, out_valid, done}, 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle without start", {62'd0, out_valid, done}, 64'd0);

        for (int n = 0; n < NVEC; n++) begin
            run_vec(VECS[n], 1'b0, 1'b0, $sformatf("vec%0d", n));
        end

        run_vec(VECS[1], 1'b1, 1'b0, "backpressure");
        run_vec(VECS[2], 1'b1, 1'b0, "backpressure wide");
        run_vec(VECS[0], 1'b0, 1'b1, "R10 restart ignored");

        load(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-job", {62'd0, out_valid, done}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 stays idle after reset", {62'd0, out_valid, done}, 64'd0);
        run_vec(VECS[5], 1'b0, 1'b0, "after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule